// File: doc/BRIEF.md
# Keyed windowed watchdog timer

This block is a watchdog counter. It raises a one-cycle reset request when software stops servicing it for too long. To service it, software writes two bytes to a service address in a fixed order: 0x55 and then 0xAA. A separate control address accepts one configuration byte. That byte picks the count clock (the bus clock or a slow 1 kHz tick enable), one of three timeout lengths or "off", and an optional windowed mode. Only the first control write after reset is accepted. Later control writes are dropped, so software that has gone astray cannot reconfigure the watchdog.

In windowed mode, which only applies when the bus clock is the count clock, a service sequence must complete in the final quarter of the timeout period. A sequence that completes earlier is treated as a fault and raises the reset request at once. Debug and stop mode affect the count differently for each source: with the bus clock the count freezes, and with the slow tick the count is cleared and held at zero. The asynchronous reset input is released to the logic through a small synchronizer.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `cnt_o` is 0, `rst_req` is 0, the slow tick is the count source (`cfg_bus_src`=0), `cfg_tsel` is 3, `cfg_win` is 0 and `cfg_locked` is 0.
- R2: A control write (`wr_addr`=1) decodes the byte as bit0 = bus-clock source, bits[2:1] = timeout select, bit3 = window enable. Only the first such write after reset is accepted. It sets `cfg_locked`, loads the fields and clears the counter. Later control writes change nothing.
- R3: For timeout select t (1..3), the limit L is 2^SLOW_Et for the slow source and 2^FAST_Et for the bus source. The L-th count step raises `rst_req` for one cycle and returns the counter to 0.
- R4: With the bus source, the counter steps on every clock. With the slow source, it steps only in cycles where `tick_1k` is high.
- R5: A service write (`wr_addr`=0) of 0x55 followed by a service write of 0xAA clears the counter. Service writes never alter the configuration outputs.
- R6: Any service byte other than 0xAA after a 0x55 drops the armed state without clearing the counter, except that another 0x55 re-arms it. A 0xAA that does not directly follow a 0x55 has no effect.
- R7: With the bus source and window enabled, a sequence that completes while the counter is below L − L/4 raises `rst_req` on the next clock and clears the counter. A sequence that completes at or above L − L/4 clears the counter without a request.
- R8: With the slow source, the window bit is ignored and any completed sequence is a legal service.
- R9: With the bus source, while `dbg_mode` or `stop_mode` is high, the counter holds its value. Counting resumes from that value when both flags are low.
- R10: With the slow source, while `dbg_mode` or `stop_mode` is high, the counter is 0 and ticks are ignored. After exit, counting restarts from 0.
- R11: Timeout select 0 disables the watchdog: the counter stays 0 and `rst_req` never rises.
- R12: `rst_req` is never high on two consecutive cycles. A service sequence that completes on the same step as the terminal count wins, so no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | 0 = service address, 1 = control address |
| wr_data | input | 8 | Write data byte |
| tick_1k | input | 1 | Slow tick enable, one clock wide |
| dbg_mode | input | 1 | Debug-mode flag |
| stop_mode | input | 1 | Stop-mode flag |
| rst_req | output | 1 | Reset request pulse |
| cnt_o | output | CNT_W | Current watchdog count |
| cfg_bus_src | output | 1 | Active source: 1 = bus clock |
| cfg_tsel | output | 2 | Active timeout select |
| cfg_win | output | 1 | Stored window enable |
| cfg_locked | output | 1 | Configuration has been taken |

## Verification
The assertions assume that every write strobe lasts one clock and that the mode flags and the tick change only between clock edges. The bench drives all inputs on the falling edge and pulses `wr_en` and `tick_1k` for exactly one cycle. The assertions also treat the internal key-complete strobe as the only path by which a service can clear the counter. For that reason the bench never issues a control write once the lock is set, except in the directed lock test, where the property allows for it. The sweeps use small exponents, so every completion point inside every timeout length can be checked against the arithmetic window boundary.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Configuration byte layout: bit3 window, bits[2:1] timeout select, bit0 source
  typedef struct packed {
    logic       win;
    logic [1:0] tsel;
    logic       bus_src;
  } wdg_cfg_t;

  localparam wdg_cfg_t CFG_RESET = '{win: 1'b0, tsel: 2'd3, bus_src: 1'b0};

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  localparam logic ADDR_SVC  = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sh_d = 1'b1;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/wdg_cfg_lock.sv
module wdg_cfg_lock
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output wdg_cfg_t   cfg_o,
  output logic       locked_o,
  output logic       load_o
);

  wdg_cfg_t cfg_q, cfg_d;
  logic     lock_q, lock_d;
  logic     accept;

  always_comb begin
    accept = wr_en && (wr_addr == ADDR_CTRL) && !lock_q;
    cfg_d  = cfg_q;
    lock_d = lock_q;
    if (accept) begin
      cfg_d  = wdg_cfg_t'(wr_data[3:0]);
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      lock_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign locked_o = lock_q;
  assign load_o   = accept;

endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       done_o
);

  logic armed_q, armed_d;
  logic done_c;

  always_comb begin
    done_c  = svc_wr && armed_q && (svc_data == KEY_FIRE);
    armed_d = armed_q;
    if (svc_wr) armed_d = (svc_data == KEY_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign done_o = done_c;

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int SLOW_E1 = 5,
  parameter int SLOW_E2 = 8,
  parameter int SLOW_E3 = 10,
  parameter int FAST_E1 = 13,
  parameter int FAST_E2 = 16,
  parameter int FAST_E3 = 18,
  parameter int CNT_W   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdg_cfg_t         cfg,
  input  logic             load,
  input  logic             svc_done,
  input  logic             tick,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt_o,
  output logic             req_o
);

  localparam int XW = CNT_W + 1;

  function automatic logic [XW-1:0] pow2(input int e);
    logic [XW-1:0] v;
    v    = '0;
    v[e] = 1'b1;
    return v;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  int               exp_sel;
  logic [XW-1:0]    lim_m1;
  logic [XW-1:0]    win_open;
  logic             enabled, step, at_end, early, expire, fire;

  // Timeout exponent for the current source and select
  always_comb begin
    unique case ({cfg.bus_src, cfg.tsel})
      3'b0_01: exp_sel = SLOW_E1;
      3'b0_10: exp_sel = SLOW_E2;
      3'b0_11: exp_sel = SLOW_E3;
      3'b1_01: exp_sel = FAST_E1;
      3'b1_10: exp_sel = FAST_E2;
      3'b1_11: exp_sel = FAST_E3;
      default: exp_sel = SLOW_E1;
    endcase
  end

  always_comb begin
    lim_m1   = pow2(exp_sel) - XW'(1);
    win_open = pow2(exp_sel) - pow2(exp_sel - 2);
    enabled  = (cfg.tsel != 2'd0);
    step     = cfg.bus_src ? !hold : (tick && !hold);
    at_end   = ({1'b0, cnt_q} == lim_m1);
    early    = cfg.win && cfg.bus_src && svc_done && ({1'b0, cnt_q} < win_open);
    expire   = step && at_end && !svc_done;
    fire     = !load && enabled && (expire || early);
    req_d    = fire && !req_q;
  end

  // Next count: load, disable, service and slow-mode clear all return to zero
  always_comb begin
    cnt_d = cnt_q;
    if (load || !enabled || svc_done) begin
      cnt_d = '0;
    end else if (!cfg.bus_src && hold) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int SLOW_E1 = 5,
  parameter int SLOW_E2 = 8,
  parameter int SLOW_E3 = 10,
  parameter int FAST_E1 = 13,
  parameter int FAST_E2 = 16,
  parameter int FAST_E3 = 18,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = max_u(SLOW_E3, FAST_E3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             tick_1k,
  input  logic             dbg_mode,
  input  logic             stop_mode,
  output logic             rst_req,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cfg_bus_src,
  output logic [1:0]       cfg_tsel,
  output logic             cfg_win,
  output logic             cfg_locked
);

  logic     rst_n_s;
  wdg_cfg_t cfg;
  logic     cfg_load;
  logic     key_done;
  logic     svc_wr;
  logic     hold;

  assign svc_wr = wr_en && (wr_addr == ADDR_SVC);
  assign hold   = dbg_mode || stop_mode;

  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  wdg_cfg_lock u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg_o    (cfg),
    .locked_o (cfg_locked),
    .load_o   (cfg_load)
  );

  wdg_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .svc_wr   (svc_wr),
    .svc_data (wr_data),
    .done_o   (key_done)
  );

  wdg_counter #(
    .SLOW_E1 (SLOW_E1), .SLOW_E2 (SLOW_E2), .SLOW_E3 (SLOW_E3),
    .FAST_E1 (FAST_E1), .FAST_E2 (FAST_E2), .FAST_E3 (FAST_E3),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cfg      (cfg),
    .load     (cfg_load),
    .svc_done (key_done),
    .tick     (tick_1k),
    .hold     (hold),
    .cnt_o    (cnt_o),
    .req_o    (rst_req)
  );

  assign cfg_bus_src = cfg.bus_src;
  assign cfg_tsel    = cfg.tsel;
  assign cfg_win     = cfg.win;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_mode,
  input logic             stop_mode,
  input logic             key_done,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt,
  input logic             bus_src,
  input logic [1:0]       tsel,
  input logic             win,
  input logic             locked
);

  // R12: request is a single-cycle pulse
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R2: once locked, the configuration and the lock stay put
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(bus_src) && $stable(tsel) && $stable(win)));

  // R9: bus source freezes the count in debug or stop mode
  p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_src && (tsel != 2'd0) && (dbg_mode || stop_mode) && !key_done)
      |=> ($stable(cnt) && !rst_req));

  // R10: slow source clears the count in debug or stop mode
  p_slow_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_src && (dbg_mode || stop_mode)) |=> ((cnt == '0) && !rst_req));

  // R11: a disabled watchdog stays quiet
  p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'd0) |=> ((cnt == '0) && !rst_req));

  // R5: a completed key sequence restarts the count
  p_key_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_done && (tsel != 2'd0)) |=> (cnt == '0));

endmodule

bind keyed_watchdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .dbg_mode  (dbg_mode),
  .stop_mode (stop_mode),
  .key_done  (key_done),
  .rst_req   (rst_req),
  .cnt       (cnt_o),
  .bus_src   (cfg_bus_src),
  .tsel      (cfg_tsel),
  .win       (cfg_win),
  .locked    (cfg_locked)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

  localparam int SE1 = 3, SE2 = 4, SE3 = 5;
  localparam int FE1 = 4, FE2 = 5, FE3 = 6;
  localparam int CW  = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_addr;
  logic [7:0]    wr_data;
  logic          tick_1k, dbg_mode, stop_mode;
  logic          rst_req;
  logic [CW-1:0] cnt_o;
  logic          cfg_bus_src, cfg_win, cfg_locked;
  logic [1:0]    cfg_tsel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  keyed_watchdog #(
    .SLOW_E1(SE1), .SLOW_E2(SE2), .SLOW_E3(SE3),
    .FAST_E1(FE1), .FAST_E2(FE2), .FAST_E3(FE3)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_1k(tick_1k), .dbg_mode(dbg_mode), .stop_mode(stop_mode),
    .rst_req(rst_req), .cnt_o(cnt_o), .cfg_bus_src(cfg_bus_src),
    .cfg_tsel(cfg_tsel), .cfg_win(cfg_win), .cfg_locked(cfg_locked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lim(input bit bus, input int t);
    int e;
    if (bus) e = (t == 1) ? FE1 : (t == 2) ? FE2 : FE3;
    else     e = (t == 1) ? SE1 : (t == 2) ? SE2 : SE3;
    return 1 << e;
  endfunction

  function automatic logic [7:0] cbyte(input bit win, input int t, input bit bus);
    return {4'b0, win, 2'(t), bus};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    tick_1k = 1'b0; dbg_mode = 1'b0; stop_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_pulse();
    @(negedge clk);
    tick_1k = 1'b1;
    @(negedge clk);
    tick_1k = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog timer: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    tick_1k = 1'b0; dbg_mode = 1'b0; stop_mode = 1'b0;

    // R1 reset defaults
    do_reset();
    check("R1 cnt", cnt_o, 0);
    check("R1 rst_req", rst_req, 0);
    check("R1 src", cfg_bus_src, 0);
    check("R1 tsel", cfg_tsel, 3);
    check("R1 win", cfg_win, 0);
    check("R1 locked", cfg_locked, 0);

    // R4: slow default ignores clocks without tick; R3 default longest timeout
    idle(10);
    check("R4 no tick no count", cnt_o, 0);
    repeat (lim(0, 3) - 1) tick_pulse();
    check("R3 default before end", cnt_o, lim(0, 3) - 1);
    check("R3 default no req yet", rst_req, 0);
    tick_pulse();
    check("R3 default req", rst_req, 1);
    check("R3 default wrap", cnt_o, 0);

    // R3/R4/R2: timeout sweep over source and select
    for (int b = 0; b < 2; b++) begin
      for (int t = 1; t <= 3; t++) begin
        int L;
        L = lim(b[0], t);
        do_reset();
        wr(1'b1, cbyte(1'b0, t, b[0]));
        check("R2 src field", cfg_bus_src, b);
        check("R2 tsel field", cfg_tsel, t);
        check("R2 locked", cfg_locked, 1);
        if (b == 1) idle(L - 1);
        else repeat (L - 1) tick_pulse();
        check("R3 count before end", cnt_o, L - 1);
        check("R3 no early req", rst_req, 0);
        if (b == 1) idle(1);
        else tick_pulse();
        check("R3 req at L", rst_req, 1);
        check("R3 wrap to zero", cnt_o, 0);
        @(negedge clk);
        check("R12 pulse width", rst_req, 0);
        check("R4 count after wrap", cnt_o, b);
      end
    end

    // R2 lock and counter clear on first write
    do_reset();
    repeat (3) tick_pulse();
    check("R4 slow ticks", cnt_o, 3);
    wr(1'b1, 8'h03);
    check("R2 first write clears", cnt_o, 0);
    wr(1'b1, 8'h04);
    check("R2 second write ignored src", cfg_bus_src, 1);
    check("R2 second write ignored tsel", cfg_tsel, 1);
    check("R2 second write no restart", cnt_o, 1);

    // R5/R6 key sequences, bus source, longest select
    do_reset();
    wr(1'b1, 8'h07);
    idle(10);
    wr(1'b0, 8'h55);
    check("R5 armed count", cnt_o, 11);
    wr(1'b0, 8'hAA);
    check("R5 service clears", cnt_o, 0);
    check("R5 cfg untouched src", cfg_bus_src, 1);
    check("R5 cfg untouched tsel", cfg_tsel, 3);
    idle(5);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h12);
    wr(1'b0, 8'hAA);
    check("R6 abort", cnt_o, 8);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'hAA);
    check("R6 rearm", cnt_o, 0);
    idle(4);
    wr(1'b0, 8'hAA);
    check("R6 lone second byte", cnt_o, 5);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'hAA);
    check("R6 repeated second byte", cnt_o, 1);

    // R7 window sweep, R12 service beats terminal count
    for (int t = 1; t <= 3; t++) begin
      int L;
      L = lim(1'b1, t);
      for (int p = 0; p <= L - 2; p++) begin
        bit early;
        early = (p + 1) < (L - L / 4);
        do_reset();
        wr(1'b1, cbyte(1'b1, t, 1'b1));
        idle(p);
        wr(1'b0, 8'h55);
        wr(1'b0, 8'hAA);
        check("R7 window req", rst_req, early);
        check("R7 window clears", cnt_o, 0);
        @(negedge clk);
        check("R12 window pulse width", rst_req, 0);
      end
    end
    for (int p = 0; p <= lim(1'b1, 1) - 2; p++) begin
      do_reset();
      wr(1'b1, cbyte(1'b0, 1, 1'b1));
      idle(p);
      wr(1'b0, 8'h55);
      wr(1'b0, 8'hAA);
      check("R12 open service no req", rst_req, 0);
      check("R12 open service clears", cnt_o, 0);
    end

    // R8 window ignored on slow source
    do_reset();
    wr(1'b1, cbyte(1'b1, 1, 1'b0));
    repeat (2) tick_pulse();
    wr(1'b0, 8'h55);
    wr(1'b0, 8'hAA);
    check("R8 slow early no req", rst_req, 0);
    check("R8 slow service clears", cnt_o, 0);

    // R9 bus hold
    do_reset();
    wr(1'b1, 8'h07);
    idle(5);
    dbg_mode = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 debug hold", cnt_o, 5);
    end
    dbg_mode = 1'b0;
    idle(3);
    check("R9 resume", cnt_o, 8);
    stop_mode = 1'b1;
    idle(3);
    check("R9 stop hold", cnt_o, 8);
    stop_mode = 1'b0;
    idle(1);
    check("R9 stop resume", cnt_o, 9);

    // R10 slow clear
    do_reset();
    wr(1'b1, 8'h06);
    repeat (4) tick_pulse();
    check("R10 before stop", cnt_o, 4);
    stop_mode = 1'b1;
    @(negedge clk);
    check("R10 stop clears", cnt_o, 0);
    repeat (2) tick_pulse();
    check("R10 ticks ignored", cnt_o, 0);
    stop_mode = 1'b0;
    tick_pulse();
    check("R10 restart from zero", cnt_o, 1);
    dbg_mode = 1'b1;
    @(negedge clk);
    check("R10 debug clears", cnt_o, 0);
    dbg_mode = 1'b0;

    // R11 disabled
    begin
      int hits;
      int nz;
      hits = 0;
      nz = 0;
      do_reset();
      wr(1'b1, cbyte(1'b0, 0, 1'b1));
      for (int i = 0; i < 300; i++) begin
        if (i == 100) begin
          wr_addr = 1'b0; wr_data = 8'h55; wr_en = 1'b1;
        end else if (i == 101) begin
          wr_data = 8'hAA;
        end else begin
          wr_en = 1'b0;
        end
        @(negedge clk);
        if (rst_req) hits++;
        if (cnt_o != 0) nz++;
      end
      wr_en = 1'b0;
      check("R11 no request", hits, 0);
      check("R11 count held zero", nz, 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule